// File: doc/BRIEF.md
# Shadow-Banked Integer Register File

This block is the integer register file of a 64-bit core that runs privileged firmware. It holds 32 architectural registers and an 8-entry shadow bank, for 40 physical entries. While an access is marked privileged, a fixed group of eight architectural indices is steered to the shadow bank instead of the main array. Firmware therefore gets private scratch registers without saving or restoring the interrupted program's values.

Each operand carries its own privilege bit: the two read sources, the single write destination and a debug read port. The steering is decided per access, so no mode-switch sequence copies values between banks. A reset loads the core identifier into two architectural registers and clears every other entry. Register 31 is a hard zero.

Top module: `banked_int_regfile`

## Requirements
- R1: The file stores 40 entries of 64 bits: architectural indices 0..31 plus 8 shadow entries. Both source ports and the debug port read combinationally from the current contents.
- R2: For an access whose privilege bit is 1, indices 8,9,10,11,12,13,14 address shadow entries 0..6 in ascending order, and index 25 addresses shadow entry 7.
- R3: For an access whose privilege bit is 0, and for any index outside {8..14, 25}, the architectural array is addressed. Such a write leaves all shadow entries unchanged.
- R4: The steering of each source port and of the write port follows that port's own privilege bit only. The two sources may read the same index in different modes in one cycle.
- R5: While reset is low, architectural registers 0 and 16 take the value on `core_id_i` and all other entries, shadow included, become zero.
- R6: Index 31 reads as zero on every read port in both modes, and writes to index 31 are discarded in both modes.
- R7: A write with `wr_en_i` high updates its entry at the rising clock edge. A read of that entry in the same cycle returns the old value, and from the next cycle it returns the new value.
- R8: The debug port reads any index and applies the same steering when `dbg_priv_i` is 1. It returns the same value a source port would return for the same index and privilege bit.
- R9: When `wr_en_i` is low, no entry changes, whatever the other write inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| core_id_i | input | 64 | Core identifier loaded into registers 0 and 16 during reset |
| rs1_priv_i | input | 1 | Privilege bit of source 1 |
| rs1_idx_i | input | 5 | Architectural index of source 1 |
| rs1_data_o | output | 64 | Source 1 read data |
| rs2_priv_i | input | 1 | Privilege bit of source 2 |
| rs2_idx_i | input | 5 | Architectural index of source 2 |
| rs2_data_o | output | 64 | Source 2 read data |
| wr_en_i | input | 1 | Write enable |
| wr_priv_i | input | 1 | Privilege bit of the destination |
| wr_idx_i | input | 5 | Architectural index of the destination |
| wr_data_i | input | 64 | Write data |
| dbg_priv_i | input | 1 | Privilege bit of the debug read |
| dbg_idx_i | input | 5 | Architectural index of the debug read |
| dbg_data_o | output | 64 | Debug read data |

## Verification
The bench goes after the two edges of the steered range: index 7 against 8, index 14 against 15, and the lone index 25 next to 24 and 26. A design with an off-by-one slot mapping would return a neighbouring shadow value, or would leak a privileged write into the program-visible register. Cross-mode pairs check bank isolation: a privileged and an unprivileged read of the same index in one cycle, and an unprivileged write followed by a privileged read. Swapped or shared privilege bits would show identical data where two values are expected. Same-cycle write-and-read pairs catch an unintended bypass, and writes to index 31 in both modes catch a zero register that can be written.

// File: rtl/srf_pkg.sv
package srf_pkg;
  localparam int SRF_DATA_W   = 64;
  localparam int SRF_ARCH     = 32;
  localparam int SRF_SHADOW   = 8;
  localparam int SRF_IDX_W    = $clog2(SRF_ARCH);
  localparam int SRF_PHYS     = SRF_ARCH + SRF_SHADOW;
  localparam int SRF_PHYS_W   = $clog2(SRF_PHYS);
  localparam int SRF_ZERO_IDX = SRF_ARCH - 1;
  // steered indices: a contiguous run plus one lone index
  localparam int SRF_RUN_LO   = 8;
  localparam int SRF_RUN_LEN  = 7;
  localparam int SRF_LONE     = 25;
  // entries seeded with the core identifier at reset
  localparam int SRF_BOOT_A   = 0;
  localparam int SRF_BOOT_B   = 16;

  // true when a privileged access to idx lands in the shadow bank
  function automatic logic srf_hits_shadow(input logic priv, input logic [SRF_IDX_W-1:0] idx);
    int unsigned u;
    u = int'(idx);
    return priv && ((u >= SRF_RUN_LO && u < SRF_RUN_LO + SRF_RUN_LEN) || u == SRF_LONE);
  endfunction

  // architectural index -> physical entry
  function automatic logic [SRF_PHYS_W-1:0] srf_redirect(input logic priv, input logic [SRF_IDX_W-1:0] idx);
    int unsigned u;
    logic [SRF_PHYS_W-1:0] p;
    u = int'(idx);
    p = SRF_PHYS_W'(u);
    if (srf_hits_shadow(priv, idx)) begin
      if (u == SRF_LONE) p = SRF_PHYS_W'(SRF_ARCH + SRF_RUN_LEN);
      else               p = SRF_PHYS_W'(SRF_ARCH + u - SRF_RUN_LO);
    end
    return p;
  endfunction
endpackage

// File: rtl/srf_remap.sv
module srf_remap
  import srf_pkg::*;
#(
  parameter int IDX_W  = SRF_IDX_W,
  parameter int PHYS_W = SRF_PHYS_W
) (
  input  logic              priv_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [PHYS_W-1:0] phys_o,
  output logic              shadow_o,
  output logic              zero_o
);
  always_comb begin
    phys_o   = srf_redirect(priv_i, idx_i);
    shadow_o = srf_hits_shadow(priv_i, idx_i);
    zero_o   = (int'(idx_i) == SRF_ZERO_IDX);
  end
endmodule

// File: rtl/srf_storage.sv
module srf_storage
  import srf_pkg::*;
#(
  parameter int DATA_W  = SRF_DATA_W,
  parameter int ARCH    = SRF_ARCH,
  parameter int ENTRIES = SRF_PHYS,
  parameter int PHYS_W  = SRF_PHYS_W,
  parameter int NRD     = 3,
  parameter int BOOT_A  = SRF_BOOT_A,
  parameter int BOOT_B  = SRF_BOOT_B,
  parameter int ZERO_E  = SRF_ZERO_IDX
) (
  input  logic                        clk_i,
  input  logic                        rst_n_i,
  input  logic [DATA_W-1:0]           boot_val_i,
  input  logic                        we_i,
  input  logic [PHYS_W-1:0]           waddr_i,
  input  logic [DATA_W-1:0]           wdata_i,
  input  logic [NRD-1:0][PHYS_W-1:0]  raddr_i,
  output logic [NRD-1:0][DATA_W-1:0]  rdata_o
);
  localparam int SHADOW_N = ENTRIES - ARCH;

  logic [ENTRIES-1:0][DATA_W-1:0] mem_q;
  logic [SHADOW_N-1:0][DATA_W-1:0] shadow_view;
  logic wr_in_range;

  assign shadow_view = mem_q[ENTRIES-1:ARCH];
  assign wr_in_range = (int'(waddr_i) < ENTRIES);

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) begin
      for (int e = 0; e < ENTRIES; e++)
        mem_q[e] <= (e == BOOT_A || e == BOOT_B) ? boot_val_i : '0;
    end else if (we_i && wr_in_range) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar p = 0; p < NRD; p++) begin : g_rd
    assign rdata_o[p] = (int'(raddr_i[p]) < ENTRIES) ? mem_q[raddr_i[p]] : '0;
  end

  // R5: seeded entries carry the identifier when reset is released
  a_r5_boot_seed: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(rst_n_i) |-> (mem_q[BOOT_A] == $past(boot_val_i) && mem_q[BOOT_B] == $past(boot_val_i)));
  // R7: an accepted write is present one cycle later
  a_r7_write_lands: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (we_i && wr_in_range) |=> mem_q[$past(waddr_i)] == $past(wdata_i));
  // R3: a write to the main array leaves the shadow bank alone
  a_r3_shadow_isolated: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (we_i && int'(waddr_i) < ARCH) |=> $stable(shadow_view));
  // R9: no enable, no change
  a_r9_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !we_i |=> $stable(mem_q));
  // R6: the gating above this module keeps the zero entry clear
  a_r6_zero_clear: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    mem_q[ZERO_E] == '0);
endmodule

// File: rtl/banked_int_regfile.sv
module banked_int_regfile
  import srf_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_n_i,
  input  logic [SRF_DATA_W-1:0] core_id_i,
  input  logic                  rs1_priv_i,
  input  logic [SRF_IDX_W-1:0]  rs1_idx_i,
  output logic [SRF_DATA_W-1:0] rs1_data_o,
  input  logic                  rs2_priv_i,
  input  logic [SRF_IDX_W-1:0]  rs2_idx_i,
  output logic [SRF_DATA_W-1:0] rs2_data_o,
  input  logic                  wr_en_i,
  input  logic                  wr_priv_i,
  input  logic [SRF_IDX_W-1:0]  wr_idx_i,
  input  logic [SRF_DATA_W-1:0] wr_data_i,
  input  logic                  dbg_priv_i,
  input  logic [SRF_IDX_W-1:0]  dbg_idx_i,
  output logic [SRF_DATA_W-1:0] dbg_data_o
);
  localparam int NRD  = 3;          // rs1, rs2, debug
  localparam int NSEL = NRD + 1;    // plus the write destination
  localparam int WSEL = NRD;

  logic [NSEL-1:0]                 sel_priv;
  logic [NSEL-1:0][SRF_IDX_W-1:0]  sel_idx;
  logic [NSEL-1:0][SRF_PHYS_W-1:0] sel_phys;
  logic [NSEL-1:0]                 sel_shadow;
  logic [NSEL-1:0]                 sel_zero;

  logic [NRD-1:0][SRF_PHYS_W-1:0]  rd_phys;
  logic [NRD-1:0][SRF_DATA_W-1:0]  rd_raw;
  logic [NRD-1:0][SRF_DATA_W-1:0]  rd_out;

  // named events for the checks
  logic st_we;
  logic wr_dropped_zero;

  assign sel_priv = {wr_priv_i, dbg_priv_i, rs2_priv_i, rs1_priv_i};
  assign sel_idx  = {wr_idx_i,  dbg_idx_i,  rs2_idx_i,  rs1_idx_i};

  for (genvar s = 0; s < NSEL; s++) begin : g_map
    srf_remap #(.IDX_W(SRF_IDX_W), .PHYS_W(SRF_PHYS_W)) u_map (
      .priv_i  (sel_priv[s]),
      .idx_i   (sel_idx[s]),
      .phys_o  (sel_phys[s]),
      .shadow_o(sel_shadow[s]),
      .zero_o  (sel_zero[s])
    );
  end

  for (genvar r = 0; r < NRD; r++) begin : g_rd
    assign rd_phys[r] = sel_phys[r];
    assign rd_out[r]  = sel_zero[r] ? '0 : rd_raw[r];
  end

  assign wr_dropped_zero = wr_en_i && sel_zero[WSEL];
  assign st_we           = wr_en_i && !sel_zero[WSEL];

  srf_storage #(
    .DATA_W (SRF_DATA_W),
    .ARCH   (SRF_ARCH),
    .ENTRIES(SRF_PHYS),
    .PHYS_W (SRF_PHYS_W),
    .NRD    (NRD),
    .BOOT_A (SRF_BOOT_A),
    .BOOT_B (SRF_BOOT_B),
    .ZERO_E (SRF_ZERO_IDX)
  ) u_store (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .boot_val_i(core_id_i),
    .we_i      (st_we),
    .waddr_i   (sel_phys[WSEL]),
    .wdata_i   (wr_data_i),
    .raddr_i   (rd_phys),
    .rdata_o   (rd_raw)
  );

  assign rs1_data_o = rd_out[0];
  assign rs2_data_o = rd_out[1];
  assign dbg_data_o = rd_out[2];

  // R8: debug port agrees with a source port on the same selection
  a_r8_dbg_matches: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (dbg_idx_i == rs1_idx_i && dbg_priv_i == rs1_priv_i) |-> dbg_data_o == rs1_data_o);
  // R4: a non-steered index reads the same in both modes
  a_r4_mode_neutral: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (rs1_idx_i == rs2_idx_i && !sel_shadow[0] && !sel_shadow[1]) |-> rs1_data_o == rs2_data_o);
  // R6: a dropped write to the zero index leaves reads of it at zero
  a_r6_zero_dropped: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    wr_dropped_zero |=> (int'(rs1_idx_i) != SRF_ZERO_IDX || rs1_data_o == '0));
endmodule

// File: tb/banked_int_regfile_tb_top.sv
module banked_int_regfile_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [63:0] core_id;
  logic        p1, p2, wp, dp, we;
  logic [4:0]  i1, i2, wi, di;
  logic [63:0] wd;
  logic [63:0] d1, d2, dd;

  int n_checks = 0;
  int n_fail   = 0;

  logic [63:0] ref_arch [32];
  logic [63:0] ref_shadow [8];
  int sh_list [8] = '{8, 9, 10, 11, 12, 13, 14, 25};

  always #5 clk = ~clk;

  banked_int_regfile dut_i (
    .clk_i(clk), .rst_n_i(rst_n), .core_id_i(core_id),
    .rs1_priv_i(p1), .rs1_idx_i(i1), .rs1_data_o(d1),
    .rs2_priv_i(p2), .rs2_idx_i(i2), .rs2_data_o(d2),
    .wr_en_i(we), .wr_priv_i(wp), .wr_idx_i(wi), .wr_data_i(wd),
    .dbg_priv_i(dp), .dbg_idx_i(di), .dbg_data_o(dd)
  );

  function automatic int slot_of(logic priv, logic [4:0] idx);
    int s = -1;
    if (priv) for (int k = 0; k < 8; k++) if (sh_list[k] == int'(idx)) s = k;
    return s;
  endfunction

  function automatic logic [63:0] ref_rd(logic priv, logic [4:0] idx);
    int s;
    if (idx == 5'd31) return 64'd0;
    s = slot_of(priv, idx);
    if (s >= 0) return ref_shadow[s];
    return ref_arch[idx];
  endfunction

  task automatic chk(string req, string port, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %h expected %h", req, port, act, exp);
    end
  endtask

  task automatic drive(logic a_p1, logic [4:0] a_i1, logic a_p2, logic [4:0] a_i2,
                       logic a_we, logic a_wp, logic [4:0] a_wi, logic [63:0] a_wd,
                       logic a_dp, logic [4:0] a_di);
    p1 = a_p1; i1 = a_i1; p2 = a_p2; i2 = a_i2;
    we = a_we; wp = a_wp; wi = a_wi; wd = a_wd;
    dp = a_dp; di = a_di;
  endtask

  // inputs are set just after a falling edge; outputs checked 1 ns later,
  // before the rising edge that may commit the write
  task automatic cycle(string req);
    int s;
    #1;
    chk(req, "rs1", d1, ref_rd(p1, i1));
    chk(req, "rs2", d2, ref_rd(p2, i2));
    chk(req, "dbg", dd, ref_rd(dp, di));
    @(posedge clk);
    if (we && wi != 5'd31) begin
      s = slot_of(wp, wi);
      if (s >= 0) ref_shadow[s] = wd;
      else        ref_arch[wi]  = wd;
    end
    @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

  initial begin
    core_id = 64'hC0DE_0000_0000_0007;
    rst_n = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
    for (int k = 0; k < 32; k++) ref_arch[k] = 64'd0;
    for (int k = 0; k < 8; k++) ref_shadow[k] = 64'd0;
    ref_arch[0]  = core_id;
    ref_arch[16] = core_id;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R5: seeded registers and cleared shadow after reset
    drive(0, 0, 1, 16, 0, 0, 0, 0, 1, 9);
    cycle("R5");
    drive(1, 25, 0, 1, 0, 0, 0, 0, 0, 15);
    cycle("R5");

    // R7: write privileged 9 and read it in the same cycle (old value)
    drive(1, 9, 0, 9, 1, 1, 9, 64'hAAAA_0000_0000_0009, 1, 9);
    cycle("R7");
    // R2: privileged 9 now holds the value, unprivileged 9 does not
    drive(1, 9, 0, 9, 0, 0, 0, 0, 1, 9);
    cycle("R2");

    // R3: unprivileged write to 25 must not reach shadow slot 7
    drive(1, 25, 0, 25, 1, 0, 25, 64'hBBBB_0000_0000_0025, 0, 25);
    cycle("R3");
    drive(1, 25, 0, 25, 0, 0, 0, 0, 1, 25);
    cycle("R3");
    // R2: privileged write to 25 lands in slot 7 only
    drive(0, 24, 0, 26, 1, 1, 25, 64'hCCCC_0000_0000_0725, 1, 25);
    cycle("R2");
    drive(1, 25, 0, 25, 0, 0, 0, 0, 1, 24);
    cycle("R2");

    // R2: range edges 7/8 and 14/15 in privileged mode
    drive(0, 0, 0, 0, 1, 1, 14, 64'h1414_1414_1414_1414, 0, 0);
    cycle("R2");
    drive(0, 0, 0, 0, 1, 1, 15, 64'h1515_1515_1515_1515, 0, 0);
    cycle("R2");
    drive(0, 0, 0, 0, 1, 1, 7, 64'h0707_0707_0707_0707, 0, 0);
    cycle("R2");
    drive(1, 14, 0, 14, 0, 0, 0, 0, 1, 15);
    cycle("R2");
    drive(1, 7, 0, 7, 0, 0, 0, 0, 1, 8);
    cycle("R2");

    // R4: sources in different modes on the same steered index
    drive(0, 0, 0, 0, 1, 0, 12, 64'h0000_1200_0000_0000, 0, 0);
    cycle("R4");
    drive(0, 0, 0, 0, 1, 1, 12, 64'h5555_1200_0000_0001, 0, 0);
    cycle("R4");
    drive(1, 12, 0, 12, 0, 0, 0, 0, 0, 12);
    cycle("R4");
    drive(0, 12, 1, 12, 0, 0, 0, 0, 1, 12);
    cycle("R4");

    // R6: writes to 31 in both modes are dropped
    drive(0, 31, 1, 31, 1, 0, 31, 64'hFFFF_FFFF_FFFF_FFFF, 1, 31);
    cycle("R6");
    drive(0, 31, 1, 31, 1, 1, 31, 64'hDEAD_BEEF_DEAD_BEEF, 0, 31);
    cycle("R6");
    drive(0, 31, 1, 31, 0, 0, 0, 0, 1, 31);
    cycle("R6");

    // R9: disabled write with live address and data
    drive(0, 0, 1, 10, 0, 0, 0, 64'h9999_9999_9999_9999, 1, 10);
    cycle("R9");
    drive(0, 0, 1, 10, 0, 1, 10, 64'h8888_8888_8888_8888, 0, 0);
    cycle("R9");
    drive(0, 0, 1, 10, 0, 0, 0, 0, 1, 10);
    cycle("R9");

    // R8: debug port over every index in both modes
    for (int k = 0; k < 64; k++) begin
      drive(k[5], 5'(k), 0, 0, 0, 0, 0, 0, k[5], 5'(k));
      cycle("R8");
    end

    // R1: mixed traffic across all ports, biased toward steered indices
    for (int n = 0; n < 3000; n++) begin
      logic [4:0] pick [5];
      for (int k = 0; k < 5; k++) begin
        case ($urandom_range(0, 3))
          0: pick[k] = 5'($urandom_range(8, 14));
          1: pick[k] = 5'(sh_list[$urandom_range(0, 7)] == 8 ? 25 : 16);
          default: pick[k] = 5'($urandom_range(0, 31));
        endcase
      end
      drive(1'($urandom), pick[0], 1'($urandom), pick[1],
            ($urandom_range(0, 3) != 0), 1'($urandom), pick[2],
            {$urandom(), $urandom()}, 1'($urandom), pick[3]);
      cycle("R1");
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end
endmodule